// File: doc/BRIEF.md
# CAN Receive Mailbox Dispatcher

This block sits behind a CAN receiver that has already decoded and checked a frame. The frame arrives as an 11-bit identifier, a length code and eight data bytes, with a one-cycle valid strobe. The block compares the identifier with a set of per-mailbox acceptance identifiers. It then stores the frame in the single mailbox that wins the match. Frames that match nothing leave every mailbox untouched.

Each mailbox is built at elaboration time in one of three kinds:
- A **basic** buffer holds the first unread frame.
- A **full** buffer always keeps the newest frame.
- An **extended** mailbox queues frames in a hardware FIFO. It raises its interrupt only once per programmable number of stored frames.

Software selects a mailbox, reads the frame at its head, and acknowledges the read with a strobe. The same strobe pops the FIFO. Pending flags are cleared by writing one to them. The default build has three mailboxes: a basic one for identifier 0x005, a full one for 0x250, and a 4-deep FIFO for 0x3FF that interrupts on every 4th frame.

Top module: `can_rx_dispatch`

## Requirements
- R1: A frame whose identifier matches no mailbox changes no pending flag, no overrun flag and no stored content.
- R2: When several mailboxes carry the same identifier, only the lowest-numbered one stores the frame.
- R3: A full mailbox stores the identifier, length and data of every matching frame, overwriting any older content. The frame is readable on the next cycle, and `cpu_rd_valid` goes high for it.
- R4: A full mailbox sets its overrun bit (`mbx_ovr`) when it overwrites a frame not yet acknowledged. A read strobe on that mailbox clears both the bit and the stored-frame indication.
- R5: A basic mailbox keeps its first unread frame. A further matching frame is discarded and sets the overrun bit. Every matching frame sets the pending flag.
- R6: An extended mailbox returns frames in arrival order. Each read strobe removes the head; a strobe on an empty mailbox has no effect.
- R7: An extended mailbox sets its pending flag once per IRQ_THRESH frames it accepts, not on the frames in between.
- R8: When the FIFO holds FIFO_DEPTH frames and no pop occurs, a matching frame is dropped. The mailbox's overrun bit then acts as a sticky overflow flag, and the queued frames are kept unchanged.
- R9: Writing one to a bit of `mbx_clr` clears that mailbox's pending flag, and also its overflow flag when it is an extended mailbox. A new set condition in the same cycle wins over the clear.
- R10: If a frame is stored and the same mailbox is read in the same cycle, the read returns the previous content and the new frame is held afterwards. For a full mailbox, this case does not set overrun.
- R11: `irq` is high exactly when at least one pending flag is set.
- R12: After reset, every mailbox is empty and all flags and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received frame |
| rx_id | input | 11 | Received identifier |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data bytes, byte 0 in bits 7:0 |
| cpu_sel | input | SEL_W | Mailbox selected for reading |
| cpu_rd | input | 1 | Acknowledge the selected mailbox (read or pop) |
| mbx_clr | input | NUM_MBX | Write-one-to-clear pending/overflow flags |
| cpu_rd_valid | output | 1 | Selected mailbox holds a frame |
| cpu_rd_id | output | 11 | Identifier of the selected frame |
| cpu_rd_dlc | output | 4 | Length code of the selected frame |
| cpu_rd_data | output | 64 | Data of the selected frame |
| mbx_pend | output | NUM_MBX | Per-mailbox pending interrupt flags |
| mbx_ovr | output | NUM_MBX | Per-mailbox overrun (buffer) or overflow (FIFO) flags |
| irq | output | 1 | Combined interrupt |

## Verification
Inputs are registered in one step:
- A frame or acknowledge applied before a rising edge shows on the stored content, the flags and `irq` right after that edge.
- The read outputs follow `cpu_sel` within the same cycle, from the state in the mailboxes.

The bench drives inputs just after the falling edge and steps its own queue-based model on the rising edge. It compares every output on each falling edge, so every result is checked in the first cycle it is due, and stale values are caught as well.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
    localparam int ID_W   = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } can_frame_t;

    typedef enum logic [1:0] {
        MBX_BASIC = 2'd0,
        MBX_FULL  = 2'd1,
        MBX_EXT   = 2'd2
    } mbx_mode_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/can_id_match.sv
module can_id_match
    import can_mbx_pkg::*;
#(
    parameter int NUM_MBX = 3,
    parameter logic [NUM_MBX*ID_W-1:0] MBX_IDS = '0
) (
    input  logic            valid,
    input  logic [ID_W-1:0] id,
    output logic [NUM_MBX-1:0] hit
);
    logic found;

    always_comb begin
        hit   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_MBX; i++) begin
            if (valid && !found && (id == MBX_IDS[i*ID_W +: ID_W])) begin
                hit[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // R2: at most one mailbox wins any frame
    always_comb begin
        p_single_winner_r2: assert ($onehot0(hit));
    end
endmodule

// File: rtl/can_mbx_slot.sv
module can_mbx_slot
    import can_mbx_pkg::*;
#(
    parameter bit OVERWRITE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  can_frame_t frame_in,
    input  logic       rd,
    input  logic       clr,
    output can_frame_t frame_out,
    output logic       valid,
    output logic       pend,
    output logic       ovr
);
    logic store;
    logic lost;

    // a basic buffer refuses new content while unread; a full one always takes it
    assign store = push && (OVERWRITE || !valid || rd);
    assign lost  = push && valid && !rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_out <= '0;
            valid     <= 1'b0;
            pend      <= 1'b0;
            ovr       <= 1'b0;
        end else begin
            if (store) frame_out <= frame_in;
            valid <= store | (valid & ~rd);
            pend  <= push | (pend & ~clr);
            ovr   <= lost | (ovr & ~rd);
        end
    end

    p_pend_on_rx_r3: assert property (@(posedge clk) disable iff (rst)
        push |=> pend);
    p_ovr_on_loss_r4: assert property (@(posedge clk) disable iff (rst)
        (push && valid && !rd) |=> ovr);
    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rd && !push) |=> (!valid && !ovr));
    p_basic_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (!OVERWRITE && push && valid && !rd) |=> $stable(frame_out));
endmodule

// File: rtl/can_mbx_fifo.sv
module can_mbx_fifo
    import can_mbx_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int THRESH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  can_frame_t frame_in,
    input  logic       rd,
    input  logic       clr,
    output can_frame_t frame_out,
    output logic       valid,
    output logic       pend,
    output logic       ovf
);
    localparam int PW = idx_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int TW = idx_width(THRESH);

    can_frame_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic [TW-1:0] tcnt;
    logic          full, pop, accept, wrap;

    assign full   = (count == CW'(DEPTH));
    assign pop    = rd && (count != '0);
    assign accept = push && (!full || pop);
    assign wrap   = (tcnt == TW'(THRESH - 1));

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= frame_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            tcnt   <= '0;
            pend   <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (accept) wr_ptr <= nxt(wr_ptr);
            if (pop)    rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(accept) - CW'(pop);
            if (accept) tcnt <= wrap ? '0 : tcnt + 1'b1;
            pend <= (accept && wrap) | (pend & ~clr);
            ovf  <= (push && !accept) | (ovf & ~clr);
        end
    end

    assign frame_out = mem[rd_ptr];
    assign valid     = (count != '0);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && ovf));
    p_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && !accept) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/can_rx_dispatch.sv
module can_rx_dispatch
    import can_mbx_pkg::*;
#(
    parameter int NUM_MBX = 3,
    parameter logic [NUM_MBX*ID_W-1:0] MBX_IDS   = {11'h3FF, 11'h250, 11'h005},
    parameter logic [NUM_MBX*2-1:0]    MBX_MODES = {MBX_EXT, MBX_FULL, MBX_BASIC},
    parameter int FIFO_DEPTH = 4,
    parameter int IRQ_THRESH = 4,
    localparam int SEL_W = idx_width(NUM_MBX)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [ID_W-1:0]    rx_id,
    input  logic [DLC_W-1:0]   rx_dlc,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic [SEL_W-1:0]   cpu_sel,
    input  logic               cpu_rd,
    input  logic [NUM_MBX-1:0] mbx_clr,
    output logic               cpu_rd_valid,
    output logic [ID_W-1:0]    cpu_rd_id,
    output logic [DLC_W-1:0]   cpu_rd_dlc,
    output logic [DATA_W-1:0]  cpu_rd_data,
    output logic [NUM_MBX-1:0] mbx_pend,
    output logic [NUM_MBX-1:0] mbx_ovr,
    output logic               irq
);
    can_frame_t         rx_frame;
    can_frame_t         mbx_frame [NUM_MBX];
    logic [NUM_MBX-1:0] hit, mbx_valid, mbx_rd;

    assign rx_frame = '{id: rx_id, dlc: rx_dlc, data: rx_data};

    can_id_match #(.NUM_MBX(NUM_MBX), .MBX_IDS(MBX_IDS)) u_match (
        .valid(rx_valid), .id(rx_id), .hit(hit)
    );

    for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
        assign mbx_rd[i] = cpu_rd && (cpu_sel == SEL_W'(i));
        if (MBX_MODES[i*2 +: 2] == 2'(MBX_EXT)) begin : g_fifo
            can_mbx_fifo #(.DEPTH(FIFO_DEPTH), .THRESH(IRQ_THRESH)) u_fifo (
                .clk(clk), .rst(rst), .push(hit[i]), .frame_in(rx_frame),
                .rd(mbx_rd[i]), .clr(mbx_clr[i]), .frame_out(mbx_frame[i]),
                .valid(mbx_valid[i]), .pend(mbx_pend[i]), .ovf(mbx_ovr[i])
            );
        end else begin : g_slot
            can_mbx_slot #(.OVERWRITE(MBX_MODES[i*2 +: 2] == 2'(MBX_FULL))) u_slot (
                .clk(clk), .rst(rst), .push(hit[i]), .frame_in(rx_frame),
                .rd(mbx_rd[i]), .clr(mbx_clr[i]), .frame_out(mbx_frame[i]),
                .valid(mbx_valid[i]), .pend(mbx_pend[i]), .ovr(mbx_ovr[i])
            );
        end
    end

    always_comb begin
        cpu_rd_valid = 1'b0;
        cpu_rd_id    = '0;
        cpu_rd_dlc   = '0;
        cpu_rd_data  = '0;
        for (int i = 0; i < NUM_MBX; i++) begin
            if (cpu_sel == SEL_W'(i)) begin
                cpu_rd_valid = mbx_valid[i];
                cpu_rd_id    = mbx_frame[i].id;
                cpu_rd_dlc   = mbx_frame[i].dlc;
                cpu_rd_data  = mbx_frame[i].data;
            end
        end
    end

    assign irq = |mbx_pend;

    p_no_match_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && hit == '0 && mbx_clr == '0 && !cpu_rd)
        |=> ($stable(mbx_pend) && $stable(mbx_ovr) && $stable(mbx_valid)));
    p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
        (mbx_pend != '0) |-> irq);
    p_reset_quiet_r12: assert property (@(posedge clk)
        $past(rst) |-> (!irq && mbx_valid == '0 && mbx_ovr == '0));
endmodule

// File: tb/can_rx_dispatch_tb.sv
module can_rx_dispatch_tb;
    localparam int N = 4;
    localparam int D = 4;
    localparam int T = 4;
    localparam int SW = 2;
    localparam int EXT = 1;
    // mode codes: 0 basic, 1 full, 2 extended; identifiers packed with mailbox 0 lowest
    localparam logic [N*11-1:0] IDS   = {11'h250, 11'h250, 11'h3FF, 11'h005};
    localparam logic [N*2-1:0]  MODES = {2'd1, 2'd1, 2'd2, 2'd0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 1'b0;
    logic [10:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic [SW-1:0] cpu_sel = '0;
    logic cpu_rd = 1'b0;
    logic [N-1:0] mbx_clr = '0;
    logic cpu_rd_valid;
    logic [10:0] cpu_rd_id;
    logic [3:0]  cpu_rd_dlc;
    logic [63:0] cpu_rd_data;
    logic [N-1:0] mbx_pend, mbx_ovr;
    logic irq;

    always #2.5 clk = ~clk;

    can_rx_dispatch #(.NUM_MBX(N), .MBX_IDS(IDS), .MBX_MODES(MODES),
                      .FIFO_DEPTH(D), .IRQ_THRESH(T)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_dlc(rx_dlc),
        .rx_data(rx_data), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .mbx_clr(mbx_clr),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_id(cpu_rd_id), .cpu_rd_dlc(cpu_rd_dlc),
        .cpu_rd_data(cpu_rd_data), .mbx_pend(mbx_pend), .mbx_ovr(mbx_ovr), .irq(irq)
    );

    // behavioural reference
    logic [78:0] m_buf [N];
    bit          m_val [N];
    bit          m_pend [N];
    bit          m_ovr [N];
    logic [78:0] m_q [$];
    int          m_tc;
    int checks = 0;
    int errors = 0;
    string cur_req = "R12";

    function automatic int mode_of(input int i);
        return int'(MODES[i*2 +: 2]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_val[i] = 0; m_pend[i] = 0; m_ovr[i] = 0; m_buf[i] = '0;
            end
            m_q.delete();
            m_tc = 0;
        end else begin
            int win;
            win = -1;
            if (rx_valid)
                for (int i = 0; i < N; i++)
                    if (win < 0 && rx_id == IDS[i*11 +: 11]) win = i;
            for (int i = 0; i < N; i++) begin
                bit push, rdi;
                push = (win == i);
                rdi  = cpu_rd && (int'(cpu_sel) == i);
                if (mode_of(i) == 2) begin
                    bit pop, acc;
                    pop = rdi && m_q.size() > 0;
                    acc = push && (m_q.size() < D || pop);
                    if (pop) void'(m_q.pop_front());
                    m_pend[i] = m_pend[i] && !mbx_clr[i];
                    m_ovr[i]  = (m_ovr[i] && !mbx_clr[i]) || (push && !acc);
                    if (acc) begin
                        m_q.push_back({rx_id, rx_dlc, rx_data});
                        m_tc++;
                        if (m_tc == T) begin m_tc = 0; m_pend[i] = 1; end
                    end
                end else begin
                    bit lost;
                    lost = push && m_val[i] && !rdi;
                    if (push && (mode_of(i) == 1 || !lost)) begin
                        m_buf[i] = {rx_id, rx_dlc, rx_data};
                        m_val[i] = 1;
                    end else if (rdi) m_val[i] = 0;
                    m_pend[i] = push || (m_pend[i] && !mbx_clr[i]);
                    m_ovr[i]  = lost || (m_ovr[i] && !rdi);
                end
            end
        end
    end

    task automatic chk(input string what, input logic [78:0] act, input logic [78:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [N-1:0] ep, eo;
        int s;
        bit ev;
        logic [78:0] ef;
        for (int i = 0; i < N; i++) begin ep[i] = m_pend[i]; eo[i] = m_ovr[i]; end
        s  = int'(cpu_sel);
        ev = (mode_of(s) == 2) ? (m_q.size() > 0) : m_val[s];
        ef = (mode_of(s) == 2) ? ((m_q.size() > 0) ? m_q[0] : '0) : m_buf[s];
        chk("pend", 79'(mbx_pend), 79'(ep));
        chk("ovr", 79'(mbx_ovr), 79'(eo));
        chk("irq", 79'(irq), 79'(|ep));
        chk("rd_valid", 79'(cpu_rd_valid), 79'(ev));
        if (ev) chk("frame", {cpu_rd_id, cpu_rd_dlc, cpu_rd_data}, ef);
    end

    task automatic step(input bit v, input logic [10:0] id, input logic [63:0] d,
                        input int sel, input bit rd, input logic [N-1:0] clr);
        @(negedge clk);
        #1;
        rx_valid = v; rx_id = id; rx_dlc = 4'(d[3:0] | 4'h1); rx_data = d;
        cpu_sel = SW'(sel); cpu_rd = rd; mbx_clr = clr;
    endtask

    task automatic idle(input int sel);
        step(0, '0, '0, sel, 0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        idle(0);
        cur_req = "R1";                       // unmatched identifier
        step(1, 11'h123, 64'h1111, 2, 0, '0); idle(2);
        cur_req = "R3";                       // full store and overwrite
        step(1, 11'h250, 64'hA0A1, 2, 0, '0); idle(2);
        cur_req = "R4";
        step(1, 11'h250, 64'hB0B2, 2, 0, '0); idle(2);
        step(0, '0, '0, 2, 1, '0); idle(2);
        cur_req = "R2";                       // duplicate identifier in mailbox 3 never filled
        idle(3);
        cur_req = "R9";
        step(0, '0, '0, 2, 0, 4'b0100); idle(2);
        cur_req = "R5";                       // basic keeps first frame
        step(1, 11'h005, 64'hC001, 0, 0, '0);
        step(1, 11'h005, 64'hC002, 0, 0, '0); idle(0);
        step(0, '0, '0, 0, 1, 4'b0001); idle(0);
        cur_req = "R7";                       // extended: threshold interrupt
        for (int k = 0; k < 3; k++) step(1, 11'h3FF, 64'(16'hD000 + k), 1, 0, '0);
        idle(1);
        step(1, 11'h3FF, 64'hD003, 1, 0, '0); idle(1);
        cur_req = "R8";
        step(1, 11'h3FF, 64'hD0FF, 1, 0, '0); idle(1);
        cur_req = "R6";
        step(0, '0, '0, 1, 1, '0);
        step(0, '0, '0, 1, 1, '0); idle(1);
        cur_req = "R10";                      // push and pop together
        step(1, 11'h3FF, 64'hE001, 1, 1, '0); idle(1);
        step(1, 11'h250, 64'hE250, 2, 0, '0);
        step(1, 11'h250, 64'hE251, 2, 1, '0); idle(2);
        cur_req = "R9";                       // clear and set in the same cycle
        step(1, 11'h250, 64'hF250, 2, 0, 4'b0110); idle(2);
        cur_req = "R6";
        for (int k = 0; k < 5; k++) step(0, '0, '0, 1, 1, '0);
        idle(1);
        cur_req = "R11";
        step(0, '0, '0, 0, 1, 4'b1111);
        step(0, '0, '0, 2, 1, '0); idle(3);
        cur_req = "R12";
        step(0, '0, '0, 0, 0, '0);
        #1 rst = 1'b1;
        idle(1); idle(1);
        #1 rst = 1'b0;
        idle(2); idle(0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule